// File: doc/BRIEF.md
# Quadrature Sweep Oscillator

This block is a numerically controlled oscillator. On every sample clock it emits one sine sample and one cosine sample, both signed 16-bit and a quarter turn apart. The sine drives converter channel A and the cosine drives channel B. The output frequency is the phase increment times the sample rate divided by 2^32. The increment either holds steady for a fixed tone or ramps linearly. In a ramp it grows by a programmed step on each sample, from a start value up to a stop value, and then wraps back to start.

Three 32-bit parameters set the oscillator: start, stop and step. Each is written in two 16-bit halves into a shadow copy. Writing a shadow changes nothing in the running core. The shadow is copied into the active set only when that parameter's own commit strobe is pulsed. A commit of the start value also restarts the ramp at once. Any start or stop value above a quarter of the sample rate is clamped to that limit when it is committed.

Top module: `qdds_sweep`

## Requirements
- R1: While rst_ni is low, sin_o and cos_o are 0 and valid_o is 0.
- R2: A write with wr_en_i high goes only to a shadow half-register, selected by wr_sel_i (0 start low, 1 start high, 2 stop low, 3 stop high, 4 step low, 5 step high). Codes 6 and 7 are ignored. Without a commit, the phase increment in use does not change.
- R3: commit_i bit 0 copies the start shadow into the active set and loads it as the current increment on the next edge. Bit 1 commits stop and bit 2 commits step. Each bit acts independently of the others.
- R4: On every sample the phase accumulator adds the current increment, modulo 2^32. Its top 10 bits select the output angle.
- R5: When current increment plus step is greater than stop, the next increment is start. Otherwise the next increment is current plus step.
- R6: When start equals stop and step is 1, the increment stays constant and the tone is fixed.
- R7: Start and stop values above 0x40000000 are clamped to 0x40000000 on commit.
- R8: For angle index a (0..1023), sin_o equals round(32767*sin(2*pi*(a+0.5)/1024)). Rounding is half away from zero.
- R9: cos_o equals round(32767*cos(2*pi*(a+0.5)/1024)) for the same index a. This is the sine of index a+256.
- R10: sin_o and cos_o show the angle held by the accumulator one edge earlier. valid_o is 1 from the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Shadow half-register write enable |
| wr_sel_i | input | 3 | Half-register select |
| wr_data_i | input | 16 | Half-register write data |
| commit_i | input | 3 | Commit strobes: bit 0 start, bit 1 stop, bit 2 step |
| sin_o | output | 16 | Sine sample, channel A, two's complement |
| cos_o | output | 16 | Cosine sample, channel B, two's complement |
| valid_o | output | 1 | Samples valid |

## Verification
A wrong increment shows up at the ports within a few samples: the sequence of angle indices stops matching the expected ramp, and a bad reload point shifts every later sample. A wrong table entry or a wrong quadrant fold is visible only when the accumulator reaches that index. For that reason one run walks all 1024 angles at one index per sample, and other runs sweep the increment across its range and across the clamp. A mistake in how a shadow is committed appears as a frequency change either a cycle early, a cycle late, or not at all.

// File: rtl/qdds_pkg.sv
package qdds_pkg;
  typedef enum logic [1:0] {
    PRM_START = 2'd0,
    PRM_STOP  = 2'd1,
    PRM_STEP  = 2'd2
  } prm_e;
  localparam int unsigned NPRM = 3;
endpackage

// File: rtl/qdds_regs.sv
module qdds_regs
  import qdds_pkg::*;
#(
  parameter int unsigned PH_W   = 32,
  parameter int unsigned HALF_W = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [2:0]                     wr_sel_i,
  input  logic [HALF_W-1:0]              wr_data_i,
  input  logic [NPRM-1:0]                commit_i,
  output logic [NPRM-1:0][PH_W-1:0]      shadow_o,
  output logic [NPRM-1:0][PH_W-1:0]      active_o,
  output logic [PH_W-1:0]                start_load_o
);
  localparam int unsigned NHALF = PH_W / HALF_W;
  localparam logic [PH_W-1:0] CAP = PH_W'(1) << (PH_W - 2);

  logic [NPRM-1:0][PH_W-1:0] shadow_q, active_q;

  for (genvar p = 0; p < NPRM; p++) begin : g_prm
    for (genvar h = 0; h < NHALF; h++) begin : g_half
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) shadow_q[p][h*HALF_W +: HALF_W] <= '0;
        else if (wr_en_i && wr_sel_i == 3'(p*NHALF + h))
          shadow_q[p][h*HALF_W +: HALF_W] <= wr_data_i;
      end
    end
    // step is not an increment, so only start and stop are limited
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) active_q[p] <= '0;
      else if (commit_i[p]) begin
        if (p != int'(PRM_STEP) && shadow_q[p] > CAP) active_q[p] <= CAP;
        else active_q[p] <= shadow_q[p];
      end
    end
  end

  assign start_load_o = (shadow_q[PRM_START] > CAP) ? CAP : shadow_q[PRM_START];
  assign shadow_o     = shadow_q;
  assign active_o     = active_q;
endmodule

// File: rtl/qdds_core.sv
module qdds_core #(
  parameter int unsigned PH_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            restart_i,
  input  logic [PH_W-1:0] load_i,
  input  logic [PH_W-1:0] start_i,
  input  logic [PH_W-1:0] stop_i,
  input  logic [PH_W-1:0] step_i,
  output logic [PH_W-1:0] phase_o,
  output logic [PH_W-1:0] inc_o
);
  logic [PH_W-1:0] phase_q, inc_q;
  logic [PH_W:0]   next_sum;

  assign next_sum = {1'b0, inc_q} + {1'b0, step_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      inc_q   <= '0;
    end else begin
      phase_q <= phase_q + inc_q;
      if (restart_i)                       inc_q <= load_i;
      else if (next_sum > {1'b0, stop_i})  inc_q <= start_i;
      else                                 inc_q <= next_sum[PH_W-1:0];
    end
  end

  assign phase_o = phase_q;
  assign inc_o   = inc_q;
endmodule

// File: rtl/qdds_sine.sv
module qdds_sine #(
  parameter int unsigned LUT_AW = 8,
  parameter int unsigned OUT_W  = 16
) (
  input  logic [LUT_AW+1:0]  angle_i,
  output logic [OUT_W-1:0]   sample_o
);
  localparam int unsigned DEPTH = 1 << LUT_AW;
  localparam real AMP = real'((1 << (OUT_W - 1)) - 1);
  localparam real HALF_PI = 1.5707963267948966;

  function automatic int quarter_val(int k);
    real a;
    a = AMP * $sin(HALF_PI * (real'(k) + 0.5) / real'(DEPTH));
    return $rtoi(a + 0.5);
  endfunction

  logic [OUT_W-2:0] lut [DEPTH];
  for (genvar k = 0; k < DEPTH; k++) begin : g_lut
    assign lut[k] = (OUT_W-1)'(quarter_val(k));
  end

  logic [1:0]        quad;
  logic [LUT_AW-1:0] idx;
  logic [OUT_W-1:0]  mag;

  assign quad = angle_i[LUT_AW+1:LUT_AW];
  // half-step sample offset makes the mirrored index exact
  assign idx  = quad[0] ? ~angle_i[LUT_AW-1:0] : angle_i[LUT_AW-1:0];
  assign mag  = {1'b0, lut[idx]};
  assign sample_o = quad[1] ? (~mag + 1'b1) : mag;
endmodule

// File: rtl/qdds_sweep.sv
module qdds_sweep
  import qdds_pkg::*;
#(
  parameter int unsigned PH_W   = 32,
  parameter int unsigned HALF_W = 16,
  parameter int unsigned LUT_AW = 8,
  parameter int unsigned OUT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [HALF_W-1:0] wr_data_i,
  input  logic [NPRM-1:0]   commit_i,
  output logic [OUT_W-1:0]  sin_o,
  output logic [OUT_W-1:0]  cos_o,
  output logic              valid_o
);
  localparam int unsigned ANG_W = LUT_AW + 2;

  logic [NPRM-1:0][PH_W-1:0] shadow, active;
  logic [PH_W-1:0]           start_load, phase, inc_q;
  logic [ANG_W-1:0]          angle;
  logic [1:0][OUT_W-1:0]     lut_out;
  logic [OUT_W-1:0]          sin_q, cos_q;
  logic                      valid_q;

  qdds_regs #(.PH_W(PH_W), .HALF_W(HALF_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i, .commit_i,
    .shadow_o(shadow), .active_o(active), .start_load_o(start_load)
  );

  qdds_core #(.PH_W(PH_W)) u_core (
    .clk_i, .rst_ni,
    .restart_i(commit_i[PRM_START]), .load_i(start_load),
    .start_i(active[PRM_START]), .stop_i(active[PRM_STOP]), .step_i(active[PRM_STEP]),
    .phase_o(phase), .inc_o(inc_q)
  );

  assign angle = phase[PH_W-1 -: ANG_W];

  // channel 0 sine, channel 1 a quarter turn ahead (cosine)
  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    qdds_sine #(.LUT_AW(LUT_AW), .OUT_W(OUT_W)) u_sine (
      .angle_i(angle + ANG_W'(ch << LUT_AW)),
      .sample_o(lut_out[ch])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sin_q   <= '0;
      cos_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      sin_q   <= lut_out[0];
      cos_q   <= lut_out[1];
      valid_q <= 1'b1;
    end
  end

  assign sin_o   = sin_q;
  assign cos_o   = cos_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/qdds_sweep_chk.sv
module qdds_sweep_chk #(
  parameter int unsigned PH_W = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [2:0]           commit_i,
  input logic                 valid_o,
  input logic [2:0][PH_W-1:0] shadow,
  input logic [2:0][PH_W-1:0] active,
  input logic [PH_W-1:0]      phase,
  input logic [PH_W-1:0]      inc_q
);
  localparam logic [PH_W-1:0] CAP = PH_W'(1) << (PH_W - 2);

  logic [PH_W:0] sum;
  assign sum = {1'b0, inc_q} + {1'b0, active[2]};

  p_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> valid_o);

  p_phase_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> phase == $past(phase) + $past(inc_q));

  p_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit_i[0] && sum > {1'b0, active[1]}) |=> inc_q == $past(active[0]));

  p_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit_i[0] && sum <= {1'b0, active[1]}) |=> inc_q == $past(sum[PH_W-1:0]));

  p_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i[0] |=> inc_q == (($past(shadow[0]) > CAP) ? CAP : $past(shadow[0])));

  p_stop_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i[1] |=> $stable(active[1]));

  p_cap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_q <= CAP);
endmodule

bind qdds_sweep qdds_sweep_chk #(.PH_W(PH_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .commit_i(commit_i), .valid_o(valid_o),
  .shadow(shadow), .active(active), .phase(phase), .inc_q(inc_q)
);

// File: tb/qdds_sweep_bench.sv
`timescale 1ns/1ps
module qdds_sweep_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  commit = '0;
  logic [15:0] sin_o, cos_o;
  logic        valid_o;

  int n_chk = 0;
  int n_fail = 0;
  bit sb_on = 1'b0;
  bit done = 1'b0;
  string cur_tag = "R8";

  always #4 clk = ~clk;

  qdds_sweep u_qdds_sweep (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .commit_i(commit),
    .sin_o(sin_o), .cos_o(cos_o), .valid_o(valid_o)
  );

  localparam logic [31:0] CAP = 32'h4000_0000;

  function automatic logic [15:0] ref_val(int a, bit is_cos);
    real x, v;
    x = 6.283185307179586 * (real'(a) + 0.5) / 1024.0;
    v = 32767.0 * (is_cos ? $cos(x) : $sin(x));
    if (v >= 0.0) return 16'($rtoi(v + 0.5));
    return 16'(-$rtoi(-v + 0.5));
  endfunction

  // reference model built from the requirements
  logic [2:0][31:0] m_sh, m_act;
  logic [31:0] m_ph, m_inc;
  logic [15:0] m_sin, m_cos;
  logic        m_valid;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sh <= '0; m_act <= '0; m_ph <= '0; m_inc <= '0;
      m_sin <= '0; m_cos <= '0; m_valid <= 1'b0;
    end else begin
      if (wr_en && wr_sel < 3'd6) begin
        if (wr_sel[0]) m_sh[wr_sel/2][31:16] <= wr_data;
        else           m_sh[wr_sel/2][15:0]  <= wr_data;
      end
      for (int p = 0; p < 3; p++)
        if (commit[p]) m_act[p] <= (p < 2 && m_sh[p] > CAP) ? CAP : m_sh[p];
      if (commit[0])
        m_inc <= (m_sh[0] > CAP) ? CAP : m_sh[0];
      else if (33'(m_inc) + 33'(m_act[2]) > 33'(m_act[1]))
        m_inc <= m_act[0];
      else
        m_inc <= m_inc + m_act[2];
      m_ph    <= m_ph + m_inc;
      m_sin   <= ref_val(int'(m_ph[31:22]), 1'b0);
      m_cos   <= ref_val(int'(m_ph[31:22]), 1'b1);
      m_valid <= 1'b1;
    end
  end

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (sb_on && !done) begin
      check(cur_tag, "sin_o", 32'(sin_o), 32'(m_sin));
      check("R9", "cos_o", 32'(cos_o), 32'(m_cos));
      check("R10", "valid_o", 32'(valid_o), 32'(m_valid));
    end
  end

  task automatic wr(logic [2:0] sel, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_all(logic [31:0] st, logic [31:0] sp, logic [31:0] sz);
    wr(3'd0, st[15:0]); wr(3'd1, st[31:16]);
    wr(3'd2, sp[15:0]); wr(3'd3, sp[31:16]);
    wr(3'd4, sz[15:0]); wr(3'd5, sz[31:16]);
  endtask

  task automatic pulse_commit(logic [2:0] c);
    @(negedge clk);
    commit = c;
    @(negedge clk);
    commit = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] s0;
    logic [15:0] prev_cos;
    // R1 reset values
    idle(3);
    check("R1", "sin_o", 32'(sin_o), 0);
    check("R1", "cos_o", 32'(cos_o), 0);
    check("R1", "valid_o", 32'(valid_o), 0);
    rst_n = 1'b1;
    // R10 valid after first edge, angle 0 shown
    @(negedge clk);
    check("R10", "valid_o", 32'(valid_o), 1);
    check("R10", "sin_o", 32'(sin_o), 32'(ref_val(0, 1'b0)));
    sb_on = 1'b1;

    // R2 shadow writes alone leave the tone unchanged (phase stays 0)
    cur_tag = "R2";
    set_all(32'h0100_0000, 32'h0100_0000, 32'h1);
    wr(3'd6, 16'hFFFF); wr(3'd7, 16'hFFFF);
    idle(10);
    check("R2", "sin_o idle", 32'(sin_o), 32'(ref_val(0, 1'b0)));

    // R6 fixed tone
    cur_tag = "R6";
    pulse_commit(3'b111);
    idle(2);
    s0 = sin_o;
    idle(256);  // inc 0x01000000 gives a period of 256 samples
    check("R6", "sin_o period", 32'(sin_o), 32'(s0));

    // R4 arbitrary fixed increment
    cur_tag = "R4";
    set_all(32'h0ABC_DEF1, 32'h0ABC_DEF1, 32'h1);
    pulse_commit(3'b111);
    idle(300);

    // R8 exhaustive angle walk, one index per sample
    cur_tag = "R8";
    set_all(32'h0040_0000, 32'h0040_0000, 32'h1);
    pulse_commit(3'b111);
    idle(1100);

    // R5 linear sweep with several reloads
    cur_tag = "R5";
    set_all(32'h0010_0000, 32'h0080_0000, 32'h0001_0000);
    pulse_commit(3'b111);
    idle(800);

    // R3 independent commits: stop only, then step only, then start only
    cur_tag = "R3";
    set_all(32'h0020_0000, 32'h0030_0000, 32'h0000_4000);
    pulse_commit(3'b010);
    idle(100);
    pulse_commit(3'b100);
    idle(100);
    pulse_commit(3'b001);
    idle(200);

    // R7 clamp: increment of a quarter turn, each sine equals the prior cosine
    cur_tag = "R7";
    set_all(32'hFFFF_FFFF, 32'hF000_0000, 32'h1);
    pulse_commit(3'b111);
    idle(3);
    for (int k = 0; k < 8; k++) begin
      prev_cos = cos_o;
      idle(1);
      check("R7", "sin after cap", 32'(sin_o), 32'(prev_cos));
    end
    idle(50);

    // R1 reset in mid-run
    sb_on = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    idle(1);
    check("R1", "sin_o", 32'(sin_o), 0);
    check("R1", "valid_o", 32'(valid_o), 0);
    finish_run();
  end
endmodule